// File: doc/BRIEF.md
# One-Shot Down-Counting Timer Across Two Clocks

This block is a single-shot countdown timer. Software on a fast bus clock writes a 16-bit interval, then issues a start command. The count runs on an independent timer clock that may be hundreds or thousands of times slower. It counts from the interval value down to zero once. On reaching zero it raises a zero event, which latches a sticky interrupt flag on the bus side. The counter then holds at zero until it is started again.

The run/enable state belongs to the slow domain. It clears itself one timer-clock edge after the zero event. The bus-side view of enable therefore still reads 1 for a while after the interrupt appears. A start written in that window is dropped without effect. Software that restarts from the interrupt handler writes stop first, or stop and start together, and the new interval then begins. Commands go from the bus side to the timer side as toggles through two-flop synchronizers. Events come back the same way, and the zero event becomes a one-bus-cycle pulse.

Top module: `oneshot_dntimer`

## Requirements
- R1: After reset, the interval register (address 0), the control register (address 1, bit 0 = enable) and the status register (address 2, bit 0 = interrupt flag) all read 0, and `irq` is 0.
- R2: A write to address 0 stores all 16 data bits as the interval, and a read of address 0 returns them.
- R3: A write to address 1 with bit 0 set and bit 1 clear, while enable reads 0, sets enable at once and starts a count from the interval. Counting timer-clock rising edges from the write, `irq` rises after exactly interval+3 edges.
- R4: After the zero event, enable keeps reading 1 until the next timer edge's clear has crossed back. A start written in that window has no effect: no further interrupt follows, and enable then reads 0.
- R5: A start written while a count is running is ignored. It neither reloads nor retimes the count, even if the interval register has changed.
- R6: Bit 1 of a control write (stop) clears enable in the next bus cycle and cancels a running count, so no zero event follows. A start written after it begins a fresh count, with the R3 timing measured from the start write.
- R7: A control write with bits 1 and 0 both set restarts the timer with the current interval, whatever the enable state, with the R3 timing measured from that write.
- R8: The interrupt flag stays set until a write to address 2 with bit 0 set clears it. `irq` always equals the flag.
- R9: When a clear write and an arriving zero event fall in the same bus cycle, the flag remains set.
- R10: Once a count has finished, the counter stays at zero and issues no further zero events until it is started again.
- R11: An interval of 0 behaves like an interval of 1: the zero event comes on the first timer edge after the start takes effect, so `irq` rises 4 timer edges after the start write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Register-side clock |
| busRstN | input | 1 | Active-low reset, bus domain |
| tmrClk | input | 1 | Counting clock |
| tmrRstN | input | 1 | Active-low reset, timer domain |
| busValid | input | 1 | Access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register select: 0 interval, 1 control, 2 status |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for `busAddr` (combinational) |
| irq | output | 1 | Zero-event interrupt flag |

## Verification
Two functions can fall in the same bus cycle. One is a software clear of the interrupt flag. The other is a zero pulse coming out of the return synchronizer. The bench provokes the overlap by starting a short count and then writing the clear bit on every bus cycle across the expected arrival. A design where clear wins would never show `irq` high during that stream. A correct design shows it high right after the colliding edge, and it stays high once the stream stops. A second overlap is a stop and a start in one control write. The timer side must let the start win when both toggles arrive on the same edge, and the bench checks this through the restart latency.

// File: rtl/oneshot_dntimer_pkg.sv
package oneshot_dntimer_pkg;

  localparam int ADDR_W       = 2;
  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_HLT_BIT = 1;
  localparam int STAT_IRQ_BIT = 0;

  typedef enum logic [ADDR_W-1:0] {
    REG_LOAD = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2
  } regSel_t;

  // Bus domain -> timer domain command toggles
  typedef struct packed {
    logic startTgl;
    logic stopTgl;
  } tmrCmd_t;

  // Timer domain -> bus domain event toggles and start echo
  typedef struct packed {
    logic zeroTgl;
    logic doneTgl;
    logic ackTgl;
  } tmrEvt_t;

  // Bus-side visible state
  typedef struct packed {
    logic en;
    logic irq;
  } busView_t;

endpackage

// File: rtl/ost_sync.sv
module ost_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/ost_ctrl.sv
module ost_ctrl
  import oneshot_dntimer_pkg::*;
#(
  parameter int LOAD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [LOAD_W-1:0] busWdata,
  output logic [LOAD_W-1:0] busRdata,
  input  tmrEvt_t           evtAsync,
  output tmrCmd_t           cmd,
  output logic [LOAD_W-1:0] armedLoad,
  output busView_t          view
);

  localparam int EVT_W = $bits(tmrEvt_t);

  logic [EVT_W-1:0] evtSyncVec;
  tmrEvt_t          evtSync;
  logic             zeroPrev, donePrev;
  logic             zeroPulse, donePulse, startPending;
  logic             wrLoad, wrCtrl, wrStat;
  logic             startReq, stopReq, startTake, clrReq;
  logic [LOAD_W-1:0] loadReg;
  logic             enReg, irqReg;

  ost_sync #(.WIDTH(EVT_W), .STAGES(SYNC_STAGES)) u_evtSync (
    .clk (clk),
    .rstN(rstN),
    .d   (evtAsync),
    .q   (evtSyncVec)
  );
  assign evtSync = tmrEvt_t'(evtSyncVec);

  always_comb begin
    wrLoad = busValid && busWrite && (regSel_t'(busAddr) == REG_LOAD);
    wrCtrl = busValid && busWrite && (regSel_t'(busAddr) == REG_CTRL);
    wrStat = busValid && busWrite && (regSel_t'(busAddr) == REG_STAT);
    startReq  = wrCtrl && busWdata[CTRL_RUN_BIT];
    stopReq   = wrCtrl && busWdata[CTRL_HLT_BIT];
    clrReq    = wrStat && busWdata[STAT_IRQ_BIT];
    // a start is honoured only from a stopped view, or bundled with a stop
    startTake = startReq && (stopReq || !enReg);
    zeroPulse = evtSync.zeroTgl ^ zeroPrev;
    donePulse = evtSync.doneTgl ^ donePrev;
    // a completion belongs to an older run while the latest start is unechoed
    startPending = cmd.startTgl ^ evtSync.ackTgl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroPrev  <= 1'b0;
      donePrev  <= 1'b0;
      loadReg   <= '0;
      armedLoad <= '0;
      enReg     <= 1'b0;
      irqReg    <= 1'b0;
      cmd       <= '0;
    end else begin
      zeroPrev <= evtSync.zeroTgl;
      donePrev <= evtSync.doneTgl;
      if (wrLoad) loadReg <= busWdata;
      if (startTake) begin
        armedLoad    <= loadReg;
        cmd.startTgl <= ~cmd.startTgl;
      end
      if (stopReq) cmd.stopTgl <= ~cmd.stopTgl;
      if (startTake)                      enReg <= 1'b1;
      else if (stopReq)                   enReg <= 1'b0;
      else if (donePulse && !startPending) enReg <= 1'b0;
      // arriving event outranks a same-cycle clear
      irqReg <= zeroPulse | (irqReg & ~clrReq);
    end
  end

  always_comb begin
    busRdata = '0;
    case (regSel_t'(busAddr))
      REG_LOAD: busRdata = loadReg;
      REG_CTRL: busRdata[CTRL_RUN_BIT] = enReg;
      REG_STAT: busRdata[STAT_IRQ_BIT] = irqReg;
      default:  busRdata = '0;
    endcase
  end

  assign view.en  = enReg;
  assign view.irq = irqReg;

endmodule

// File: rtl/ost_datapath.sv
module ost_datapath
  import oneshot_dntimer_pkg::*;
#(
  parameter int LOAD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrCmd_t           cmdAsync,
  input  logic [LOAD_W-1:0] armedLoad,
  output tmrEvt_t           evt
);

  localparam int CMD_W = $bits(tmrCmd_t);

  logic [CMD_W-1:0] cmdSyncVec;
  tmrCmd_t          cmdSync, cmdPrev;
  logic             startEdge, stopEdge;
  logic [LOAD_W-1:0] cnt;
  logic             run, hit;
  logic             zeroTgl, doneTgl;

  ost_sync #(.WIDTH(CMD_W), .STAGES(SYNC_STAGES)) u_cmdSync (
    .clk (clk),
    .rstN(rstN),
    .d   (cmdAsync),
    .q   (cmdSyncVec)
  );
  assign cmdSync = tmrCmd_t'(cmdSyncVec);

  assign startEdge = cmdSync.startTgl ^ cmdPrev.startTgl;
  assign stopEdge  = cmdSync.stopTgl  ^ cmdPrev.stopTgl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdPrev <= '0;
      cnt     <= '0;
      run     <= 1'b0;
      hit     <= 1'b0;
      zeroTgl <= 1'b0;
      doneTgl <= 1'b0;
    end else begin
      cmdPrev <= cmdSync;
      if (startEdge) begin
        cnt <= armedLoad;
        run <= 1'b1;
        hit <= 1'b0;
      end else if (stopEdge) begin
        run <= 1'b0;
      end else if (run && hit) begin
        run     <= 1'b0;
        doneTgl <= ~doneTgl;
      end else if (run && (cnt <= LOAD_W'(1))) begin
        cnt     <= '0;
        hit     <= 1'b1;
        zeroTgl <= ~zeroTgl;
      end else if (run) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign evt.zeroTgl = zeroTgl;
  assign evt.doneTgl = doneTgl;
  assign evt.ackTgl  = cmdPrev.startTgl;

endmodule

// File: rtl/oneshot_dntimer.sv
module oneshot_dntimer
  import oneshot_dntimer_pkg::*;
#(
  parameter int LOAD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              tmrClk,
  input  logic              tmrRstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [LOAD_W-1:0] busWdata,
  output logic [LOAD_W-1:0] busRdata,
  output logic              irq
);

  tmrCmd_t           cmd;
  tmrEvt_t           evt;
  busView_t          view;
  logic [LOAD_W-1:0] armedLoad;

  ost_ctrl #(.LOAD_W(LOAD_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (busClk),
    .rstN     (busRstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .evtAsync (evt),
    .cmd      (cmd),
    .armedLoad(armedLoad),
    .view     (view)
  );

  ost_datapath #(.LOAD_W(LOAD_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (tmrClk),
    .rstN     (tmrRstN),
    .cmdAsync (cmd),
    .armedLoad(armedLoad),
    .evt      (evt)
  );

  assign irq = view.irq;

endmodule

// File: rtl/ost_checker.sv
module ost_checker
  import oneshot_dntimer_pkg::*;
(
  input logic              busClk,
  input logic              busRstN,
  input logic              tmrClk,
  input logic              tmrRstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        wdLow,
  input tmrCmd_t           cmd,
  input tmrEvt_t           evt,
  input busView_t          view
);

  logic wrCtrl, wrClr;
  assign wrCtrl = busValid && busWrite && (busAddr == ADDR_W'(REG_CTRL));
  assign wrClr  = busValid && busWrite && (busAddr == ADDR_W'(REG_STAT)) && wdLow[0];

  p_start_launch_r3: assert property (@(posedge busClk) disable iff (!busRstN)
    (wrCtrl && wdLow == 2'b01 && !view.en) |=> (view.en && cmd.startTgl != $past(cmd.startTgl)));

  p_start_ignored_r5: assert property (@(posedge busClk) disable iff (!busRstN)
    (wrCtrl && wdLow == 2'b01 && view.en) |=> $stable(cmd.startTgl));

  p_stop_drops_en_r6: assert property (@(posedge busClk) disable iff (!busRstN)
    (wrCtrl && wdLow == 2'b10) |=> (!view.en && cmd.stopTgl != $past(cmd.stopTgl)));

  p_restart_both_r7: assert property (@(posedge busClk) disable iff (!busRstN)
    (wrCtrl && wdLow == 2'b11) |=> (view.en && cmd.startTgl != $past(cmd.startTgl)
                                    && cmd.stopTgl != $past(cmd.stopTgl)));

  p_irq_sticky_r8: assert property (@(posedge busClk) disable iff (!busRstN)
    (view.irq && !wrClr) |=> view.irq);

  p_zero_single_r10: assert property (@(posedge tmrClk) disable iff (!tmrRstN)
    !$stable(evt.zeroTgl) |=> $stable(evt.zeroTgl));

  p_done_after_zero_r4: assert property (@(posedge tmrClk) disable iff (!tmrRstN)
    !$stable(evt.doneTgl) |-> ($stable(evt.zeroTgl)
                               && $past(evt.zeroTgl) != $past(evt.zeroTgl, 2)));

endmodule

bind oneshot_dntimer ost_checker u_chk (
  .busClk  (busClk),
  .busRstN (busRstN),
  .tmrClk  (tmrClk),
  .tmrRstN (tmrRstN),
  .busValid(busValid),
  .busWrite(busWrite),
  .busAddr (busAddr),
  .wdLow   (busWdata[1:0]),
  .cmd     (cmd),
  .evt     (evt),
  .view    (view)
);

// File: tb/oneshot_dntimer_bench.sv
module oneshot_dntimer_bench;

  logic        busClk = 1'b0;
  logic        tmrClk = 1'b0;
  logic        busRstN = 1'b0;
  logic        tmrRstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [15:0] busWdata = 16'd0;
  logic [15:0] busRdata;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  int tmrEdges = 0;

  oneshot_dntimer u_oneshot_dntimer (
    .busClk  (busClk),
    .busRstN (busRstN),
    .tmrClk  (tmrClk),
    .tmrRstN (tmrRstN),
    .busValid(busValid),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .irq     (irq)
  );

  // 50 MHz bus clock; timer clock 100x slower, offset so edges never coincide
  always #10 busClk = ~busClk;
  initial begin
    #7;
    forever #1000 tmrClk = ~tmrClk;
  end
  always @(posedge tmrClk) tmrEdges <= tmrEdges + 1;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge busClk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge busClk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    @(negedge busClk);
    busAddr = a;
    #2;
    d = int'(busRdata);
  endtask

  task automatic waitTmr(input int n);
    int s = tmrEdges;
    while (tmrEdges - s < n) @(negedge busClk);
  endtask

  // returns timer edges elapsed from 'since' when irq seen, -1 if not within limit
  task automatic waitIrq(input int since, input int limit, output int lat);
    lat = -1;
    while (tmrEdges - since < limit) begin
      @(negedge busClk);
      if (irq) begin lat = tmrEdges - since; break; end
    end
  endtask

  task automatic waitIdle();
    int v = 1;
    for (int i = 0; i < 40 && v != 0; i++) begin
      waitTmr(1);
      rd(2'd1, v);
    end
  endtask

  task automatic tReset();
    int v;
    rd(2'd0, v); chk("R1 load reset", v, 0);
    rd(2'd1, v); chk("R1 ctrl reset", v, 0);
    rd(2'd2, v); chk("R1 stat reset", v, 0);
    chk("R1 irq reset", int'(irq), 0);
  endtask

  task automatic tLoadReg();
    int v;
    wr(2'd0, 16'hBEEF); rd(2'd0, v); chk("R2 load readback", v, 16'hBEEF);
    wr(2'd0, 16'h1234); rd(2'd0, v); chk("R2 load readback2", v, 16'h1234);
  endtask

  task automatic tOneshotStale();
    int v, t0, lat;
    wr(2'd0, 16'd5); wr(2'd1, 16'h1); t0 = tmrEdges;
    rd(2'd1, v); chk("R3 enable set", v, 1);
    waitIrq(t0, 30, lat); chk("R3 latency load5", lat, 8);
    rd(2'd1, v); chk("R4 stale enable", v, 1);
    wr(2'd1, 16'h1);                 // start inside stale window: dropped
    wr(2'd2, 16'h1); chk("R8 irq cleared", int'(irq), 0);
    waitTmr(12);
    chk("R4 late start ignored", int'(irq), 0);
    rd(2'd1, v); chk("R4 enable cleared", v, 0);
    rd(2'd2, v); chk("R10 no repeat event", v, 0);
  endtask

  task automatic tStopStart();
    int v, t0, lat;
    wr(2'd0, 16'd3); wr(2'd1, 16'h1); t0 = tmrEdges;
    waitIrq(t0, 30, lat); chk("R3 latency load3", lat, 6);
    wr(2'd2, 16'h1);
    wr(2'd1, 16'h2);
    rd(2'd1, v); chk("R6 stop clears enable", v, 0);
    wr(2'd0, 16'd7); wr(2'd1, 16'h1); t0 = tmrEdges;
    rd(2'd1, v); chk("R6 restart enable", v, 1);
    waitIrq(t0, 30, lat); chk("R6 stop+start latency", lat, 10);
    wr(2'd2, 16'h1);
    waitIdle();
  endtask

  task automatic tZeroLoad();
    int t0, lat;
    wr(2'd0, 16'd0); wr(2'd1, 16'h1); t0 = tmrEdges;
    waitIrq(t0, 30, lat); chk("R11 zero load latency", lat, 4);
    wr(2'd2, 16'h1);
    waitIdle();
  endtask

  task automatic tBusyStart();
    int t0, lat;
    wr(2'd0, 16'd20); wr(2'd1, 16'h1); t0 = tmrEdges;
    waitTmr(5);
    wr(2'd0, 16'd2); wr(2'd1, 16'h1);   // ignored while running
    waitIrq(t0, 40, lat); chk("R5 busy start ignored", lat, 23);
    wr(2'd2, 16'h1);
    waitIdle();
  endtask

  task automatic tStopCancel();
    int v;
    wr(2'd0, 16'd15); wr(2'd1, 16'h1);
    waitTmr(4);
    wr(2'd1, 16'h2);
    waitTmr(25);
    chk("R6 stop cancels", int'(irq), 0);
    rd(2'd1, v); chk("R6 stopped enable", v, 0);
  endtask

  task automatic tRestartBits();
    int v, t0, lat;
    wr(2'd0, 16'd30); wr(2'd1, 16'h1);
    waitTmr(5);
    wr(2'd0, 16'd4); wr(2'd1, 16'h3); t0 = tmrEdges;
    rd(2'd1, v); chk("R7 restart enable", v, 1);
    waitIrq(t0, 40, lat); chk("R7 restart latency", lat, 7);
    wr(2'd2, 16'h1);
    waitIdle();
    chk("R10 hold after restart", int'(irq), 0);
  endtask

  task automatic tClearCollide();
    int v, t0;
    bit seen = 0;
    wr(2'd0, 16'd2); wr(2'd1, 16'h1); t0 = tmrEdges;
    @(negedge busClk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = 2'd2; busWdata = 16'h1;
    while (!seen && tmrEdges - t0 < 12) begin
      @(negedge busClk);
      if (irq) seen = 1;
    end
    busValid = 1'b0; busWrite = 1'b0;
    chk("R9 set wins over clear", int'(seen), 1);
    waitTmr(1);
    rd(2'd2, v); chk("R9 flag kept", v, 1);
    wr(2'd2, 16'h1);
    waitIdle();
  endtask

  initial begin
    #(200_000 * 20);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #8010;
    busRstN = 1'b1;
    tmrRstN = 1'b1;
    tReset();
    tLoadReg();
    tOneshotStale();
    tStopStart();
    tZeroLoad();
    tBusyStart();
    tStopCancel();
    tRestartBits();
    tClearCollide();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule